// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Bus Controller

This block sits between a clocked user port and an asynchronous pseudo-static RAM of 256K words by 16 bits. The user presents a request with a direction, an 18-bit word address, a two-bit byte mask and write data. The request is held until a single-cycle acknowledge comes back. For reads, the acknowledge carries the returned word. The controller drives the memory's chip enable, output enable, write enable and the two byte-lane strobes. The bidirectional data pin appears as separate in, out and drive-enable signals.

Every access is timed by cycle counts that are fixed at elaboration. Each nanosecond limit of the chosen speed grade is divided by the clock period and rounded up. A write is the window in which write enable, chip enable and at least one byte strobe are all low. The controller opens and closes this window on chip enable and write enable together. Reads are controlled by chip enable: the address and byte strobes are settled one cycle before chip enable falls. After a read, the write drivers stay off for a turnaround guard, because the memory can keep driving for a while after its output enable is released.

The state machine has seven states. From IDLE, a read request goes to RD_SETUP; a write request goes to WR_SETUP once the turnaround guard has expired. RD_SETUP always moves to RD_ACCESS. RD_ACCESS holds for the read count, then moves to RD_DONE, which acknowledges and returns to IDLE. WR_SETUP always moves to WR_PULSE. WR_PULSE holds for the write count, then moves to WR_HOLD, which acknowledges and returns to IDLE.

Top module: `psram_ctrl`

## Requirements
- R1: During and after reset, before any request, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are high, and mem_dq_oe and ack are low.
- R2: The address and the enabled byte strobes are on the pins for one full cycle before mem_ce_n falls. The address does not change while mem_ce_n is low.
- R3: A read holds mem_ce_n and mem_oe_n low together for ceil(tRC/T) cycles with mem_we_n high. ack is then high for the cycle after they rise, with the word on rd_data.
- R4: In req_be, bit 0 enables bits [7:0] (mem_lb_n) and bit 1 enables bits [15:8] (mem_ub_n). The strobe of a disabled lane stays high, and on a read that lane of rd_data returns zero.
- R5: A write holds mem_ce_n and mem_we_n low together for NW cycles, where NW = max(ceil(tSCE/T), ceil(tAW/T), ceil(tPWE/T), ceil(tWC/T)-2). mem_oe_n stays high during the write. mem_dq_oe rises on the same edge on which mem_we_n falls.
- R6: mem_addr and mem_dq_out are unchanged while mem_we_n is low and for the cycle after it rises. mem_dq_oe is still high in that cycle, and ack is high in it.
- R7: mem_dq_oe is never high while mem_oe_n is low.
- R8: After a read, mem_dq_oe rises no sooner than ceil(25 ns/T) cycles after mem_oe_n rose.
- R9: Each request gets exactly one ack, which is high for a single cycle.
- R10: A masked write changes only the enabled lanes of the addressed word. The other lane keeps its old value.
- R11: With a 5 ns clock and the 70 ns grade, mem_ce_n is low for 70 ns on a read and 60 ns on a write. From the request, ack comes 16 cycles later for a read and 14 cycles later for a write that follows a write or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte enables, bit 0 low lane, bit 1 high lane |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read word, valid with ack |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dq_in | input | 16 | Data from the memory pins |
| mem_dq_out | output | 16 | Data toward the memory pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
Writes use a full mask, a low-lane-only mask and a high-lane-only mask, each followed by read-back under full and partial masks. A lane that is written in error, or one that fails to be masked to zero, shows up in these reads. Walking-one data over the lowest, highest and middle addresses shows whether address and data bits are swapped or stuck. Write-after-write and read-after-read sequences give exact latencies and strobe durations. A write directly after a read exercises the turnaround guard and the limits on pulse, setup and hold, which a time-stamping memory model measures in nanoseconds.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } psram_state_e;

    // nanoseconds to clock cycles, rounded up
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // timing limits per speed grade (grade given as its cycle time in ns)
    function automatic int t_cycle(input int grade);
        return grade;
    endfunction

    function automatic int t_we_pulse(input int grade);
        return (grade >= 70) ? 45 : 40;
    endfunction

    function automatic int t_ce_to_end(input int grade);
        return (grade >= 70) ? 60 : 45;
    endfunction

    function automatic int t_addr_to_end(input int grade);
        return (grade >= 70) ? 55 : 45;
    endfunction

    localparam int T_BUS_RELEASE_NS = 25;

endpackage

// File: rtl/psram_timer.sv
`timescale 1ns/1ps
module psram_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_datapath.sv
`timescale 1ns/1ps
module psram_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  be_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            be_q    <= in_be;
            wdata_q <= in_wdata;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata_q[l*8 +: 8] <= '0;
            end else if (capture) begin
                rdata_q[l*8 +: 8] <= be_q[l] ? dq_in[l*8 +: 8] : 8'h00;
            end
        end
    end
endmodule

// File: rtl/psram_ctrl.sv
`timescale 1ns/1ps
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 10,
    parameter int SPEED_GRADE_NS = 70,
    parameter int ADDR_W         = 18,
    parameter int DATA_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    localparam int LANES = DATA_W / 8;
    localparam int N_RD  = max2(1, ns_to_cyc(t_cycle(SPEED_GRADE_NS), CLK_PERIOD_NS));
    localparam int N_WR  = max2(max2(ns_to_cyc(t_ce_to_end(SPEED_GRADE_NS), CLK_PERIOD_NS),
                                     ns_to_cyc(t_addr_to_end(SPEED_GRADE_NS), CLK_PERIOD_NS)),
                                max2(ns_to_cyc(t_we_pulse(SPEED_GRADE_NS), CLK_PERIOD_NS),
                                     max2(1, ns_to_cyc(t_cycle(SPEED_GRADE_NS), CLK_PERIOD_NS) - 2)));
    localparam int N_TA  = ns_to_cyc(T_BUS_RELEASE_NS, CLK_PERIOD_NS);
    localparam int N_MAX = max2(max2(N_RD, N_WR), N_TA);
    localparam int CW    = $clog2(N_MAX + 2);

    psram_state_e state_q, state_d;
    logic         phase_zero, turn_zero;
    logic         phase_load, turn_load;
    logic [CW-1:0] phase_val;
    logic         accept, capture;
    logic [LANES-1:0] be_q, be_next;
    logic [DATA_W-1:0] wdata_q;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d    = state_q;
        phase_load = 1'b0;
        phase_val  = '0;
        turn_load  = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req && !req_we) begin
                    state_d = ST_RD_SETUP;
                end else if (req && req_we && turn_zero) begin
                    state_d = ST_WR_SETUP;
                end
            end
            ST_RD_SETUP: begin
                state_d    = ST_RD_ACCESS;
                phase_load = 1'b1;
                phase_val  = CW'(N_RD - 1);
            end
            ST_RD_ACCESS: begin
                if (phase_zero) begin
                    state_d   = ST_RD_DONE;
                    capture   = 1'b1;
                    turn_load = 1'b1;
                end
            end
            ST_RD_DONE:  state_d = ST_IDLE;
            ST_WR_SETUP: begin
                state_d    = ST_WR_PULSE;
                phase_load = 1'b1;
                phase_val  = CW'(N_WR - 1);
            end
            ST_WR_PULSE: begin
                if (phase_zero) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && (state_d != ST_IDLE);
    assign be_next = accept ? req_be : be_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- registered memory-side outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            ack       <= 1'b0;
        end else begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            ack       <= 1'b0;
            unique case (state_d)
                ST_IDLE: ;
                ST_RD_SETUP, ST_WR_SETUP: begin
                    mem_lb_n <= !be_next[0];
                    mem_ub_n <= !be_next[1];
                end
                ST_RD_ACCESS: begin
                    mem_ce_n <= 1'b0;
                    mem_oe_n <= 1'b0;
                    mem_lb_n <= !be_next[0];
                    mem_ub_n <= !be_next[1];
                end
                ST_RD_DONE: ack <= 1'b1;
                ST_WR_PULSE: begin
                    mem_ce_n  <= 1'b0;
                    mem_we_n  <= 1'b0;
                    mem_dq_oe <= 1'b1;
                    mem_lb_n  <= !be_next[0];
                    mem_ub_n  <= !be_next[1];
                end
                ST_WR_HOLD: begin
                    mem_dq_oe <= 1'b1;
                    mem_lb_n  <= !be_next[0];
                    mem_ub_n  <= !be_next[1];
                    ack       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- sub-blocks ----------------
    psram_timer #(.CW(CW)) i_phase_timer (
        .clk(clk), .rst_n(rst_n), .load(phase_load), .load_val(phase_val), .zero(phase_zero)
    );

    psram_timer #(.CW(CW)) i_turn_timer (
        .clk(clk), .rst_n(rst_n), .load(turn_load), .load_val(CW'(N_TA)), .zero(turn_zero)
    );

    psram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_datapath (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .in_addr(req_addr), .in_be(req_be), .in_wdata(req_wdata), .dq_in(mem_dq_in),
        .addr_q(mem_addr), .be_q(be_q), .wdata_q(wdata_q), .rdata_q(rd_data)
    );

    assign mem_dq_out = wdata_q;

    // ---------------- assertions ----------------
    logic [CW-1:0] oe_gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     oe_gap_q <= CW'(N_TA);
        else if (!mem_oe_n)             oe_gap_q <= '0;
        else if (oe_gap_q != CW'(N_TA)) oe_gap_q <= oe_gap_q + 1'b1;
    end

    // R2
    addr_before_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> ($stable(mem_addr) && $past(!mem_lb_n || !mem_ub_n)));

    // R2
    addr_hold_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R3
    rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (ack && mem_ce_n));

    // R5
    we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe && ack));

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_gap_q >= CW'(N_TA)));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: tb/test_psram_ctrl.sv
`timescale 1ns/1ps
module test_psram_ctrl;
    localparam int  T_NS   = 5;
    localparam int  GRADE  = 70;
    localparam int  RD_LAT = 16;
    localparam int  WR_LAT = 14;
    localparam real RD_CE_NS = 70.0;
    localparam real WR_CE_NS = 60.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_in, mem_dq_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    psram_ctrl #(.CLK_PERIOD_NS(T_NS), .SPEED_GRADE_NS(GRADE)) i_psram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_in(mem_dq_in),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] mem_arr [int];
    real t_ce_fall = 0.0, t_oe_fall = 0.0, t_oe_rise = -1000.0;
    real t_we_fall = 0.0, t_addr = 0.0;
    real last_rd_ce = 0.0, last_wr_ce = 0.0;
    bit  cyc_read = 1'b0;

    always @(mem_addr) begin
        if (rst_n && !mem_ce_n)
            check(1'b0, "R2/R6", "address moved while CE low", 32'(mem_addr), 0);
        t_addr = $realtime;
    end

    always @(negedge mem_ce_n) begin
        t_ce_fall = $realtime;
        if (rst_n) check(t_addr < $realtime, "R2", "address settled before CE fall",
                         $rtoi(t_addr), $rtoi($realtime));
    end

    always @(negedge mem_oe_n) begin
        t_oe_fall = $realtime;
        cyc_read  = 1'b1;
    end

    always @(negedge mem_we_n) begin
        t_we_fall = $realtime;
        cyc_read  = 1'b0;
    end

    always @(posedge mem_oe_n) begin
        if (rst_n) begin
            check(($realtime - t_oe_fall) >= 35.0, "R3", "OE low time",
                  $rtoi($realtime - t_oe_fall), 35);
            t_oe_rise = $realtime;
        end
    end

    always @(posedge mem_ce_n) begin
        if (rst_n) begin
            if (cyc_read) begin
                last_rd_ce = $realtime - t_ce_fall;
                check(last_rd_ce >= 70.0, "R3", "read CE low time", $rtoi(last_rd_ce), 70);
            end else begin
                last_wr_ce = $realtime - t_ce_fall;
            end
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n) begin
            check(($realtime - t_we_fall) >= 45.0, "R5", "WE pulse",
                  $rtoi($realtime - t_we_fall), 45);
            check(($realtime - t_ce_fall) >= 60.0, "R5", "CE to write end",
                  $rtoi($realtime - t_ce_fall), 60);
            check(($realtime - t_addr) >= 55.0, "R5", "address to write end",
                  $rtoi($realtime - t_addr), 55);
            check(mem_dq_oe, "R6", "data driven at write end", 32'(mem_dq_oe), 1);
            begin
                logic [15:0] w;
                w = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 16'h0000;
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                mem_arr[int'(mem_addr)] = w;
            end
        end
    end

    always @(posedge mem_dq_oe) begin
        if (rst_n) check(($realtime - t_oe_rise) >= 25.0, "R8", "bus turnaround",
                         $rtoi($realtime - t_oe_rise), 25);
    end

    always @(mem_ce_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_addr) begin
        logic [15:0] v;
        v = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 16'h0000;
        if (!mem_ce_n && !mem_oe_n)
            mem_dq_in = {mem_ub_n ? 8'h5A : v[15:8], mem_lb_n ? 8'hA5 : v[7:0]};
        else
            mem_dq_in = 16'hBEEF;
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q [$];
    logic [15:0] shadow [int];
    bit          prev_ack = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n)
                check(1'b0, "R7", "bus driven while OE low", 1, 0);
            if (ack && prev_ack)
                check(1'b0, "R9", "ack longer than one cycle", 1, 0);
            if (ack && !req_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected read ack", 1, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data === e, "R4/R10", "read data", 32'(rd_data), 32'(e));
                end
            end
            prev_ack = ack;
        end
    end

    int last_lat;
    bit last_was_read = 1'b0;

    task automatic do_op(input bit we, input logic [17:0] a, input logic [1:0] be,
                         input logic [15:0] d);
        int lat;
        if (we) begin
            logic [15:0] w;
            w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
            if (be[0]) w[7:0]  = d[7:0];
            if (be[1]) w[15:8] = d[15:8];
            shadow[int'(a)] = w;
        end else begin
            logic [15:0] r;
            r = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
            exp_q.push_back({be[1] ? r[15:8] : 8'h00, be[0] ? r[7:0] : 8'h00});
        end
        req = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (!we && !mem_ce_n) begin
                check(mem_lb_n == !be[0] && mem_ub_n == !be[1], "R4", "read strobes",
                      {30'd0, mem_ub_n, mem_lb_n}, {30'd0, !be[1], !be[0]});
            end
        end while (!ack && lat < 200);
        last_lat = lat;
        req = 1'b0;
        @(negedge clk);
        check(!ack, "R9", "ack dropped after one cycle", 32'(ack), 0);
        last_was_read = !we;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack} == 7'b1111100,
              "R1", "outputs in reset",
              32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack}), 32'h7C);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack} == 7'b1111100,
              "R1", "outputs idle after reset",
              32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack}), 32'h7C);

        // full-word write, latency and CE duration (R5, R11)
        do_op(1'b1, 18'h00010, 2'b11, 16'h1234);
        check(last_lat == WR_LAT, "R11", "write latency", 32'(last_lat), 32'(WR_LAT));
        check(last_wr_ce == WR_CE_NS, "R11", "write CE low ns", $rtoi(last_wr_ce), 60);
        do_op(1'b0, 18'h00010, 2'b11, 16'h0000);
        check(last_lat == RD_LAT, "R11", "read latency", 32'(last_lat), 32'(RD_LAT));
        check(last_rd_ce == RD_CE_NS, "R11", "read CE low ns", $rtoi(last_rd_ce), 70);

        // masked writes (R10), write right after read (R8)
        do_op(1'b1, 18'h00010, 2'b01, 16'hFFCD);
        check(last_lat > WR_LAT, "R8", "write after read delayed", 32'(last_lat), 32'(WR_LAT + 1));
        do_op(1'b1, 18'h00010, 2'b10, 16'h77EE);
        check(last_lat == WR_LAT, "R11", "write after write latency", 32'(last_lat), 32'(WR_LAT));
        do_op(1'b0, 18'h00010, 2'b11, 16'h0000);
        // partial-mask reads: disabled lane reads zero (R4)
        do_op(1'b0, 18'h00010, 2'b01, 16'h0000);
        do_op(1'b0, 18'h00010, 2'b10, 16'h0000);
        check(last_lat == RD_LAT, "R3", "read after read latency", 32'(last_lat), 32'(RD_LAT));

        // address boundaries and walking ones
        do_op(1'b1, 18'h00000, 2'b11, 16'h0001);
        do_op(1'b1, 18'h3FFFF, 2'b11, 16'h8000);
        for (int i = 0; i < 16; i++) begin
            do_op(1'b1, 18'(18'h1 << i), 2'b11, 16'(16'h1 << i));
        end
        do_op(1'b0, 18'h00000, 2'b11, 16'h0000);
        do_op(1'b0, 18'h3FFFF, 2'b11, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            do_op(1'b0, 18'(18'h1 << i), 2'b11, 16'h0000);
        end

        // alternating read/write traffic
        for (int i = 0; i < 6; i++) begin
            do_op(1'b0, 18'h00010, 2'b11, 16'h0000);
            do_op(1'b1, 18'h00020 + 18'(i), 2'(i % 3 + 1), 16'hC3A5 ^ 16'(i * 16'h1111));
        end
        for (int i = 0; i < 6; i++) begin
            do_op(1'b0, 18'h00020 + 18'(i), 2'b11, 16'h0000);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9", "all reads acknowledged", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * T_NS);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule